// File: doc/BRIEF.md
# Sparse Switch-Configuration Stream Decoder

This block expands a compressed configuration stream, received one bit per cycle, into a sequence of register writes. The stream has three parts. It opens with a 12-bit mask word. A run of sparsely coded switch-control words follows. The stream ends with analog parameter words, each coded either as a small change from the same parameter in the preceding channel or as a full value.

Each write is issued as soon as its code completes. The write address counts up from zero. No expanded copy of the configuration is held. The only storage is one channel's worth of parameter values, which the delta decoding needs.

Both the input stream and the write port use valid/ready. Back-pressure is passed straight through: while a write waits on the port, no further stream bit is taken. This means at most one decoded word is ever pending. The plain `done` and `err` pins report how the last stream ended.

Top module: `sparse_cfg_decoder`

## Requirements
- R1: The first SW_W (12) accepted bits of a stream are the mask, most significant bit first. Every switch word written equals the decoded pattern XOR the mask.
- R2: Each switch word is coded as follows. Bit 1 is followed by a 4-bit position, MSB first, and sets that bit of the pattern. Bit 0 closes the word, so a word whose pattern is empty is the single bit 0. A position of 12 to 15 has no effect on the written word.
- R3: Parameters are coded in channel-major order, NUM_CH channels of PAR_PER_CH parameters each. Flag 1 is followed by an 11-bit value, MSB first. Flag 0 is followed by a 3-bit two's-complement delta, which is added modulo 2^11 to the same parameter of the previous channel.
- R4: Switch words go to addresses 0 to NUM_SW-1 in stream order. Parameter p of channel c goes to address NUM_SW + c*PAR_PER_CH + p. Parameter data is zero-extended to 12 bits.
- R5: `wr_valid` rises on the clock edge that accepts the bit completing a code. Address and data then hold until the cycle in which `wr_ready` is high.
- R6: `in_ready` equals `!wr_valid || wr_ready`, combinationally.
- R7: `done` rises on the edge that accepts the final bit of the last parameter, together with that parameter's write. It stays high until the next accepted bit, which begins a new stream whose addresses restart at 0.
- R8: `err` rises, and the decoder restarts at the mask, in either of two cases. The first is an accepted bit with `in_last` high that does not finish the last parameter. The second is a delta flag for a channel-0 parameter. Writes already made stand, and no partial code is written. `err` stays high until the next accepted bit.
- R9: After reset, `wr_valid`, `done` and `err` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream bit offered |
| in_ready | output | 1 | Stream bit can be taken |
| in_bit | input | 1 | Stream bit |
| in_last | input | 1 | Marks the final bit of a stream |
| wr_valid | output | 1 | Write pending on the configuration port |
| wr_ready | input | 1 | Configuration port takes the write |
| wr_addr | output | ADDR_W = clog2(NUM_SW+NUM_CH*PAR_PER_CH+1) | Write address |
| wr_data | output | SW_W | Write data |
| done | output | 1 | Last stream completed |
| err | output | 1 | Last stream broken |

## Verification
Every write is due on the edge that accepts its code's final bit. The flags `done` and `err` are due on that same edge, and they clear on the edge that takes the next bit. In `in_ready` there is no delay at all. The bench applies each bit at the falling edge and samples one time step later. Its behavioural reference encodes the chosen word values into a bit queue and records the expected write list. On every clock, the bench checks the ready relation and compares any completed write handshake with the head of that list. On the cycle after a stream's final bit is accepted, it checks the write and the flag.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;
  typedef enum logic [2:0] {
    ST_MASK,
    ST_SW_FLAG,
    ST_SW_IDX,
    ST_PAR_FLAG,
    ST_PAR_DELTA,
    ST_PAR_FULL
  } dec_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/cfgdec_prev_store.sv
module cfgdec_prev_store #(
  parameter int PAR_W = 11,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic [SEL_W-1:0] sel,
  input  logic             we,
  input  logic [PAR_W-1:0] wdata,
  output logic [PAR_W-1:0] rdata
);
  localparam int DEPTH = 1 << SEL_W;

  logic [PAR_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[sel] <= wdata;
  end

  assign rdata = mem[sel];
endmodule

// File: rtl/cfgdec_wr_port.sv
module cfgdec_wr_port #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic [DATA_W-1:0] load_data,
  output logic              space,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else if (load) begin
      wr_valid <= 1'b1;
      wr_addr  <= load_addr;
      wr_data  <= load_data;
    end else if (wr_ready) begin
      wr_valid <= 1'b0;
    end
  end

  assign space = !wr_valid || wr_ready;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R5
endmodule

// File: rtl/cfgdec_parser.sv
module cfgdec_parser import cfgdec_pkg::*; #(
  parameter int NUM_SW     = 1700,
  parameter int SW_W       = 12,
  parameter int IDX_W      = 4,
  parameter int NUM_CH     = 8,
  parameter int PAR_PER_CH = 37,
  parameter int PAR_W      = 11,
  parameter int DELTA_W    = 3,
  parameter int ADDR_W     = 11,
  parameter int SEL_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              in_bit,
  input  logic              in_last,
  input  logic [PAR_W-1:0]  prev_val,
  output logic [SEL_W-1:0]  par_sel,
  output logic              st_we,
  output logic [PAR_W-1:0]  st_wdata,
  output logic              emit,
  output logic [ADDR_W-1:0] emit_addr,
  output logic [SW_W-1:0]   emit_data,
  output logic              done,
  output logic              err
);
  localparam int SH_W  = imax(imax(IDX_W, DELTA_W), PAR_W);
  localparam int CNT_W = $clog2(imax(SH_W, SW_W) + 1);
  localparam int SWI_W = $clog2(NUM_SW + 1);
  localparam int CH_W  = $clog2(NUM_CH + 1);

  dec_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [SW_W-1:0]   mask, acc;
  logic [SH_W-1:0]   shreg, sh_next;
  logic [SWI_W-1:0]  sw_idx;
  logic [SEL_W-1:0]  par_p;
  logic [CH_W-1:0]   ch;
  logic [ADDR_W-1:0] addr;
  logic [PAR_W-1:0]  delta_ext, par_val;
  logic              par_done, bad, final_bit, last_p;

  assign sh_next   = {shreg[SH_W-2:0], in_bit};
  assign delta_ext = {{(PAR_W-DELTA_W){sh_next[DELTA_W-1]}}, sh_next[DELTA_W-1:0]};
  assign last_p    = (par_p == SEL_W'(PAR_PER_CH - 1));
  assign final_bit = par_done && last_p && (ch == CH_W'(NUM_CH - 1));

  always_comb begin
    emit      = 1'b0;
    emit_data = '0;
    par_done  = 1'b0;
    par_val   = '0;
    bad       = 1'b0;
    if (take) begin
      case (state)
        ST_SW_FLAG: if (!in_bit) begin
          emit      = 1'b1;
          emit_data = acc ^ mask;
        end
        ST_PAR_FLAG: bad = !in_bit && (ch == '0);
        ST_PAR_DELTA: if (cnt == CNT_W'(DELTA_W - 1)) begin
          par_done = 1'b1;
          par_val  = prev_val + delta_ext;
        end
        ST_PAR_FULL: if (cnt == CNT_W'(PAR_W - 1)) begin
          par_done = 1'b1;
          par_val  = sh_next[PAR_W-1:0];
        end
        default: ;
      endcase
      if (par_done) begin
        emit      = 1'b1;
        emit_data = SW_W'(par_val);
      end
    end
  end

  assign emit_addr = addr;
  assign par_sel   = par_p;
  assign st_we     = par_done;
  assign st_wdata  = par_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_MASK;
      cnt    <= '0;
      mask   <= '0;
      acc    <= '0;
      shreg  <= '0;
      sw_idx <= '0;
      par_p  <= '0;
      ch     <= '0;
      addr   <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else if (take) begin
      done  <= 1'b0;
      err   <= 1'b0;
      shreg <= sh_next;
      if (emit) addr <= addr + ADDR_W'(1);
      case (state)
        ST_MASK: begin
          mask <= {mask[SW_W-2:0], in_bit};
          cnt  <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(SW_W - 1)) begin
            cnt   <= '0;
            state <= ST_SW_FLAG;
          end
        end
        ST_SW_FLAG: begin
          if (in_bit) begin
            cnt   <= '0;
            state <= ST_SW_IDX;
          end else begin
            acc <= '0;
            if (sw_idx == SWI_W'(NUM_SW - 1)) begin
              sw_idx <= '0;
              state  <= ST_PAR_FLAG;
            end else begin
              sw_idx <= sw_idx + SWI_W'(1);
            end
          end
        end
        ST_SW_IDX: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(IDX_W - 1)) begin
            acc   <= acc | (SW_W'(1) << sh_next[IDX_W-1:0]);
            state <= ST_SW_FLAG;
          end
        end
        ST_PAR_FLAG: begin
          cnt   <= '0;
          state <= in_bit ? ST_PAR_FULL : ST_PAR_DELTA;
        end
        ST_PAR_DELTA, ST_PAR_FULL: begin
          cnt <= cnt + CNT_W'(1);
          if (par_done) begin
            cnt   <= '0;
            state <= ST_PAR_FLAG;
            if (last_p) begin
              par_p <= '0;
              ch    <= ch + CH_W'(1);
            end else begin
              par_p <= par_p + SEL_W'(1);
            end
          end
        end
        default: state <= ST_MASK;
      endcase
      if (final_bit || bad || in_last) begin
        state  <= ST_MASK;
        cnt    <= '0;
        acc    <= '0;
        sw_idx <= '0;
        par_p  <= '0;
        ch     <= '0;
        addr   <= '0;
        done   <= final_bit;
        err    <= !final_bit;
      end
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R8
  AST_NO_DELTA_CH0: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAR_DELTA) |-> (ch != '0)); // R3
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && take) |=> !done); // R7
endmodule

// File: rtl/sparse_cfg_decoder.sv
module sparse_cfg_decoder #(
  parameter int NUM_SW     = 1700,
  parameter int SW_W       = 12,
  parameter int IDX_W      = 4,
  parameter int NUM_CH     = 8,
  parameter int PAR_PER_CH = 37,
  parameter int PAR_W      = 11,
  parameter int DELTA_W    = 3,
  localparam int ADDR_W    = $clog2(NUM_SW + NUM_CH * PAR_PER_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_bit,
  input  logic              in_last,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [SW_W-1:0]   wr_data,
  output logic              done,
  output logic              err
);
  localparam int SEL_W = $clog2(PAR_PER_CH + 1);

  logic              take, space, st_we, emit;
  logic [SEL_W-1:0]  par_sel;
  logic [PAR_W-1:0]  st_wdata, prev_val;
  logic [ADDR_W-1:0] emit_addr;
  logic [SW_W-1:0]   emit_data;

  assign in_ready = space;
  assign take     = in_valid && space;

  cfgdec_parser #(
    .NUM_SW(NUM_SW), .SW_W(SW_W), .IDX_W(IDX_W), .NUM_CH(NUM_CH),
    .PAR_PER_CH(PAR_PER_CH), .PAR_W(PAR_W), .DELTA_W(DELTA_W),
    .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_parser (
    .clk(clk), .rst_n(rst_n), .take(take), .in_bit(in_bit), .in_last(in_last),
    .prev_val(prev_val), .par_sel(par_sel), .st_we(st_we), .st_wdata(st_wdata),
    .emit(emit), .emit_addr(emit_addr), .emit_data(emit_data),
    .done(done), .err(err)
  );

  cfgdec_prev_store #(.PAR_W(PAR_W), .SEL_W(SEL_W)) u_store (
    .clk(clk), .sel(par_sel), .we(st_we), .wdata(st_wdata), .rdata(prev_val)
  );

  cfgdec_wr_port #(.ADDR_W(ADDR_W), .DATA_W(SW_W)) u_port (
    .clk(clk), .rst_n(rst_n), .load(emit), .load_addr(emit_addr),
    .load_data(emit_data), .space(space), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !in_ready); // R6
  AST_DONE_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> wr_valid); // R7
endmodule

// File: tb/sparse_cfg_decoder_bench.sv
module sparse_cfg_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSW = 5;
  localparam int NCH = 3;
  localparam int NPP = 4;
  localparam int AW  = $clog2(NSW + NCH * NPP + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, wr_ready = 1'b1;
  logic in_ready, wr_valid, done, err;
  logic [AW-1:0] wr_addr;
  logic [11:0]   wr_data;

  int tests = 0;
  int fails = 0;
  bit bits_q[$];
  int exp_a[$];
  int exp_d[$];
  int sw_v[NSW];
  int pv[NCH][NPP];
  int sw_len;

  always #(CLK_PERIOD/2) clk = ~clk;

  sparse_cfg_decoder #(
    .NUM_SW(NSW), .NUM_CH(NCH), .PAR_PER_CH(NPP)
  ) u_sparse_cfg_decoder (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .in_last(in_last), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .done(done), .err(err)
  );

  task automatic check(input bit ok, input string what, input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, expv);
    end
  endtask

  task automatic push(input int val, input int width);
    for (int b = width - 1; b >= 0; b--) bits_q.push_back(bit'((val >> b) & 1));
  endtask

  // Behavioural encoder: builds the bit stream and the expected write list.
  task automatic build(input int mask, input bit bogus);
    bits_q.delete(); exp_a.delete(); exp_d.delete();
    push(mask, 12);
    for (int r = 0; r < NSW; r++) begin
      int m = (sw_v[r] ^ mask) & 12'hFFF;
      if (bogus && r == 0) begin push(1, 1); push(13, 4); end
      for (int k = 0; k < 12; k++) if ((m >> k) & 1) begin push(1, 1); push(k, 4); end
      push(0, 1);
      exp_a.push_back(r); exp_d.push_back(sw_v[r]);
    end
    sw_len = bits_q.size();
    for (int c = 0; c < NCH; c++) begin
      for (int p = 0; p < NPP; p++) begin
        int v = pv[c][p];
        int d = (c == 0) ? 9999 : ((v - pv[c-1][p]) & 2047);
        if (c != 0 && d >= 1024) d -= 2048;
        if (d >= -4 && d <= 3) begin push(0, 1); push(d & 7, 3); end
        else begin push(1, 1); push(v, 11); end
        exp_a.push_back(NSW + c * NPP + p); exp_d.push_back(v);
      end
    end
  endtask

  task automatic feed(input bit gaps, input bit bp, input int last_idx, input bit want_err);
    int  i = 0;
    bit  take;
    bit  pend_end = 1'b0;
    bit  pend_first = 1'b0;
    while (i < bits_q.size() || exp_a.size() > 0) begin
      @(negedge clk);
      wr_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
      if (i < bits_q.size()) begin
        in_valid = gaps ? ($urandom_range(0, 4) != 0) : 1'b1;
        in_bit   = bits_q[i];
        in_last  = (i == last_idx);
      end else begin
        in_valid = 1'b0; in_bit = 1'b0; in_last = 1'b0;
      end
      #1;
      if (pend_first) begin
        check(!done && !err, "R7 R8 flags clear after next bit", {done, err}, 0);
        pend_first = 1'b0;
      end
      if (pend_end) begin
        if (want_err) check(err && !done, "R8 err on broken stream", {done, err}, 1);
        else check(done && !err && wr_valid, "R5 R7 final write and done", {wr_valid, done, err}, 6);
        pend_end = 1'b0;
      end
      check(in_ready === (!wr_valid || wr_ready), "R6 ready relation", in_ready, !wr_valid || wr_ready);
      if (wr_valid && wr_ready) begin
        if (exp_a.size() == 0) begin
          check(1'b0, "R4 R8 unexpected write", wr_addr, 0);
        end else begin
          int ea = exp_a.pop_front();
          int ed = exp_d.pop_front();
          check(int'(wr_addr) == ea, (ea < NSW) ? "R4 switch address" : "R4 parameter address", wr_addr, ea);
          check(int'(wr_data) == ed, (ea < NSW) ? "R1 R2 switch data" : "R3 parameter data", wr_data, ed);
        end
      end
      take = in_valid && in_ready;
      @(posedge clk);
      if (take) begin
        if (i == 0) pend_first = 1'b1;
        if (i == bits_q.size() - 1) pend_end = 1'b1;
        i++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; wr_ready = 1'b1;
    #1;
    if (pend_end) begin
      if (want_err) check(err && !done, "R8 err on broken stream", {done, err}, 1);
      else check(done && !err, "R7 done at end", {done, err}, 2);
    end
    if (want_err) check(err && !wr_valid, "R8 err held, no partial write", {err, wr_valid}, 2);
    else check(done && !wr_valid, "R7 done held", {done, wr_valid}, 2);
  endtask

  task automatic set_a();
    sw_v = '{12'h000, 12'h001, 12'h800, 12'h0A0, 12'h000};
    for (int p = 0; p < NPP; p++) begin
      pv[0][p] = 100 * p + 5;
      pv[1][p] = pv[0][p] + ((p == 0) ? 3 : (p == 1) ? -4 : (p == 2) ? 0 : 2);
      pv[2][p] = (p == 0) ? 2000 : (p == 3) ? pv[1][p] + 4 : pv[1][p] + 1;
    end
  endtask

  task automatic set_b();
    sw_v = '{12'hA5C, 12'hFFF, 12'h000, 12'h5A3, 12'hA5C};
    pv[0] = '{1, 0, 2047, 1024};
    pv[1] = '{2046, 3, 3, 1020};
    pv[2] = '{2046, 5, 2, 1520};
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(!wr_valid && !done && !err && in_ready, "R9 reset state",
          {wr_valid, done, err, in_ready}, 1);

    // Stream A: zero mask, steady flow; deltas at -4, 0, +3 and a +4 that needs a full value.
    set_a(); build(12'h000, 1'b0);
    feed(1'b0, 1'b0, -1, 1'b0);

    // Stream B back to back: nonzero mask, out-of-range index, wrapping deltas, stalls.
    set_b(); build(12'hA5C, 1'b1);
    feed(1'b1, 1'b1, bits_q.size() - 1, 1'b0);

    // Delta flag on a channel-0 parameter.
    bits_q.delete(); exp_a.delete(); exp_d.delete();
    push(12'h00F, 12);
    for (int r = 0; r < NSW; r++) begin push(0, 1); exp_a.push_back(r); exp_d.push_back(12'h00F); end
    push(0, 1);
    feed(1'b1, 1'b0, -1, 1'b1);

    // Stream cut inside the first parameter's full value, marked by in_last.
    set_a(); build(12'h000, 1'b0);
    while (bits_q.size() > sw_len + 6) void'(bits_q.pop_back());
    while (exp_a.size() > NSW) begin void'(exp_a.pop_back()); void'(exp_d.pop_back()); end
    feed(1'b0, 1'b1, bits_q.size() - 1, 1'b1);

    // Recovery after an error.
    set_b(); build(12'h3C1, 1'b0);
    feed(1'b1, 1'b1, -1, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule